// File: doc/BRIEF.md
# Multi-Mode Down-Counting Timer

This block is a hardware timer that counts down on qualified clock cycles and flags an interrupt whenever its count arrives at zero. Software picks a counter width of 16 or 32 bits at run time and one of three reload behaviours. Free-running restarts from the all-ones value of the chosen width. Periodic restarts from a programmed load value. One-shot halts at zero.

A controller writes a load value, selects the mode and width, and raises the run input. The rising edge of run arms the counter. After that, every cycle with the tick input high moves the count one step. The interrupt status bit is sticky until it is cleared, and it reaches the interrupt pin only through an enable. The current count is always visible on an output port.

Top module: `mm_down_timer`

## Requirements
- R1: After reset the count output reads 0, the interrupt status reads 0 and the interrupt pin is low.
- R2: In the cycle after run_i goes from low to high, the count holds its start value. In free-running mode this is the all-ones value of the selected width. In periodic and one-shot mode it is the stored load value, truncated to the selected width. Ticks in the arming cycle are ignored.
- R3: mode_i selects the behaviour: 2'b00 is free-running, 2'b01 is periodic, 2'b10 is one-shot, and 2'b11 behaves as free-running.
- R4: While run_i stays high, every cycle with tick_i high lowers a nonzero count by exactly one. A cycle with tick_i low leaves the count unchanged.
- R5: In free-running mode, a tick while the count is zero reloads the all-ones value of the selected width.
- R6: In periodic mode, a tick while the count is zero reloads the stored load value. A load written with load_we_i while the timer is running leaves the current count unchanged and is first used at the next reload.
- R7: In one-shot mode the count stops at zero, and further ticks leave it at zero and raise no new interrupt. Only a low-then-high sequence on run_i restarts it from the load value. A load write alone does not restart it.
- R8: irq_stat_o is set by every tick whose result is a zero count. This includes a periodic reload of value 0 and a one-shot count that starts at 0. The bit stays set until irq_clr_i is high, and a set in the same cycle as a clear wins.
- R9: irq_o is high exactly when irq_stat_o and irq_en_i are both high.
- R10: With wide_i low the counter is 16 bits wide: bits 31:16 of the count read as zero and the upper bits of the load value are ignored. With wide_i high all 32 bits are used.
- R11: While run_i is low, ticks change neither the count nor the interrupt status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count qualifier; one step per high cycle |
| run_i | input | 1 | Timer enable; its rising edge arms the counter |
| wide_i | input | 1 | 1 selects 32-bit counting, 0 selects 16-bit |
| mode_i | input | 2 | 00 free-running, 01 periodic, 10 one-shot, 11 free-running |
| load_we_i | input | 1 | Write strobe for the load value |
| load_val_i | input | 32 | Load value to store |
| irq_en_i | input | 1 | Interrupt pin enable |
| irq_clr_i | input | 1 | Clears the interrupt status |
| count_o | output | 32 | Current count, upper half zero in 16-bit mode |
| irq_stat_o | output | 1 | Sticky zero-reached status |
| irq_o | output | 1 | Interrupt pin |

## Verification
The 16-bit free-running counter is swept through every value, from all-ones down to zero and back to all-ones. This separates a correct decrement and wrap from an off-by-one reload or an early status flag. Periodic mode is tried with every load value from 0 to 5 over three full periods, which tells the zero-length period and the short periods apart from the general case. The one-shot patterns set the stop at zero against a restart on run, and a load write while running against a load write at arming. A 0x12345 load in 16-bit mode separates correct truncation from a leak of the upper bits.

// File: rtl/mm_down_timer.sv
module mm_down_timer #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             wide_i,
  input  logic [1:0]       mode_i,
  input  logic             load_we_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             irq_stat_o,
  output logic             irq_o
);
  localparam logic [CNT_W-1:0] FULL_MASK   = '1;
  localparam logic [CNT_W-1:0] NARROW_MASK = {{(CNT_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q, load_q, cnt_d;
  logic             run_q, done_q, stat_q, done_d, hit;

  wire [CNT_W-1:0] mask    = wide_i ? FULL_MASK : NARROW_MASK;
  wire [CNT_W-1:0] cnt_m   = cnt_q & mask;
  wire [CNT_W-1:0] load_m  = load_q & mask;
  wire             is_per  = (mode_i == 2'b01);
  wire             is_one  = (mode_i == 2'b10);
  wire             start   = run_i & ~run_q;
  wire             step    = run_i & run_q & tick_i & ~done_q;
  wire [CNT_W-1:0] reload  = is_per ? load_m : mask;
  wire             le_one  = (cnt_m[CNT_W-1:1] == '0);

  always_comb begin
    cnt_d  = cnt_m;
    done_d = done_q;
    hit    = 1'b0;
    if (start) begin
      cnt_d  = (is_per | is_one) ? load_m : mask;
      done_d = 1'b0;
    end else if (step) begin
      if (is_one) begin
        if (le_one) begin
          cnt_d  = '0;
          done_d = 1'b1;
          hit    = 1'b1;
        end else begin
          cnt_d = cnt_m - 1'b1;
        end
      end else if (cnt_m == '0) begin
        cnt_d = reload;
        hit   = (reload == '0);
      end else begin
        cnt_d = cnt_m - 1'b1;
        hit   = (cnt_m == CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      load_q <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      run_q  <= run_i;
      done_q <= done_d;
      stat_q <= hit | (stat_q & ~irq_clr_i);
      if (load_we_i) load_q <= load_val_i;
    end
  end

  assign count_o    = cnt_m;
  assign irq_stat_o = stat_q;
  assign irq_o      = stat_q & irq_en_i;
endmodule

// File: rtl/mm_down_timer_chk.sv
module mm_down_timer_chk #(
  parameter int CNT_W    = 32,
  parameter int NARROW_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick_i,
  input logic             run_i,
  input logic             wide_i,
  input logic [1:0]       mode_i,
  input logic             irq_en_i,
  input logic             irq_clr_i,
  input logic [CNT_W-1:0] count_o,
  input logic             irq_stat_o,
  input logic             irq_o
);
  // R10
  narrow_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_i |-> (count_o[CNT_W-1:NARROW_W] == '0));

  // R4
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_i) && $past(run_i) && $past(run_i, 2) && ($past(wide_i) == wide_i)) |-> $stable(count_o));

  // R4
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_i) && $past(run_i) && $past(run_i, 2) && ($past(count_o) != '0)
     && ($past(wide_i) == wide_i)) |-> (count_o == $past(count_o) - 1'b1));

  // R7
  oneshot_stays_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_i) && $past(run_i, 2) && ($past(mode_i) == 2'b10) && ($past(count_o) == '0)) |-> (count_o == '0));

  // R8
  status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_stat_o) && !$past(irq_clr_i)) |-> irq_stat_o);

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en_i && irq_stat_o));
endmodule

bind mm_down_timer mm_down_timer_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .run_i(run_i), .wide_i(wide_i),
  .mode_i(mode_i), .irq_en_i(irq_en_i), .irq_clr_i(irq_clr_i),
  .count_o(count_o), .irq_stat_o(irq_stat_o), .irq_o(irq_o)
);

// File: tb/mm_down_timer_tb.sv
module mm_down_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n, tick, run, wide, load_we, irq_en, irq_clr;
  logic [1:0]  mode;
  logic [31:0] load_val, count;
  logic        irq_stat, irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mm_down_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .run_i(run), .wide_i(wide),
    .mode_i(mode), .load_we_i(load_we), .load_val_i(load_val),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr),
    .count_o(count), .irq_stat_o(irq_stat), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic do_tick();
    tick = 1'b1; nxt(); tick = 1'b0;
  endtask

  task automatic wr_load(input logic [31:0] v);
    load_val = v; load_we = 1'b1; nxt(); load_we = 1'b0;
  endtask

  task automatic restart();
    run = 1'b0; nxt(); run = 1'b1; nxt();
  endtask

  task automatic clr();
    irq_clr = 1'b1; nxt(); irq_clr = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int errs;
    logic [31:0] cur, e;
    rst_n = 0; tick = 0; run = 0; wide = 0; mode = 2'b00; load_we = 0;
    load_val = 0; irq_en = 0; irq_clr = 0;
    repeat (3) nxt();
    rst_n = 1; nxt();
    chk("R1 count", count, 0);
    chk("R1 stat", {31'b0, irq_stat}, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    do_tick(); do_tick();
    chk("R11 idle count", count, 0);
    chk("R11 idle stat", {31'b0, irq_stat}, 0);

    restart();
    chk("R2 free16 start", count, 32'h0000_FFFF);
    repeat (4) nxt();
    chk("R4 no tick hold", count, 32'h0000_FFFF);
    errs = 0;
    tick = 1'b1;
    for (int k = 1; k <= 65535; k++) begin
      nxt();
      if (count !== 32'(65535 - k)) errs++;
      if (k < 65535 && irq_stat !== 1'b0) errs++;
    end
    tick = 1'b0;
    chk("R4 free16 full sweep errors", errs, 0);
    chk("R8 stat at zero", {31'b0, irq_stat}, 1);
    clr();
    chk("R8 cleared", {31'b0, irq_stat}, 0);
    do_tick();
    chk("R5 free16 wrap", count, 32'h0000_FFFF);
    chk("R5 no stat on wrap", {31'b0, irq_stat}, 0);

    run = 1'b0; nxt();
    do_tick(); do_tick(); do_tick();
    chk("R11 run low hold", count, 32'h0000_FFFF);

    wide = 1'b1; restart();
    chk("R10 free32 start", count, 32'hFFFF_FFFF);
    do_tick(); do_tick(); do_tick();
    chk("R4 free32 steps", count, 32'hFFFF_FFFC);

    mode = 2'b11; wr_load(32'h10); restart();
    chk("R3 mode 11 acts free", count, 32'hFFFF_FFFF);

    mode = 2'b01;
    for (int l = 0; l <= 5; l++) begin
      wr_load(32'(l)); restart();
      chk("R2 periodic start", count, 32'(l));
      cur = 32'(l);
      for (int t = 0; t < (l + 1) * 3; t++) begin
        e = (cur == 0) ? 32'(l) : cur - 1;
        do_tick();
        chk("R6 periodic count", count, e);
        if (e == 0) begin
          chk("R8 periodic stat", {31'b0, irq_stat}, 1);
          clr();
        end else begin
          chk("R8 periodic no stat", {31'b0, irq_stat}, 0);
        end
        cur = e;
      end
    end

    wr_load(32'd4); restart();
    do_tick(); do_tick();
    wr_load(32'd9);
    chk("R6 load while running", count, 32'd2);
    do_tick(); do_tick(); clr();
    do_tick();
    chk("R6 new load at reload", count, 32'd9);

    mode = 2'b10; wr_load(32'd3); restart();
    chk("R3 oneshot start", count, 32'd3);
    do_tick(); do_tick(); do_tick();
    chk("R7 oneshot zero", count, 0);
    chk("R8 oneshot stat", {31'b0, irq_stat}, 1);
    irq_en = 1'b0; nxt();
    chk("R9 masked", {31'b0, irq}, 0);
    irq_en = 1'b1; nxt();
    chk("R9 enabled", {31'b0, irq}, 1);
    repeat (4) do_tick();
    chk("R7 stays zero", count, 0);
    clr();
    chk("R9 cleared pin", {31'b0, irq}, 0);
    repeat (3) do_tick();
    chk("R7 no new stat", {31'b0, irq_stat}, 0);
    wr_load(32'd2);
    chk("R7 load no restart", count, 0);
    restart();
    chk("R7 restart", count, 32'd2);
    do_tick();
    tick = 1'b1; irq_clr = 1'b1; nxt(); tick = 1'b0; irq_clr = 1'b0;
    chk("R8 set beats clear", {31'b0, irq_stat}, 1);
    clr();
    wr_load(32'd0); restart();
    chk("R7 oneshot zero load", count, 0);
    do_tick();
    chk("R8 oneshot zero load stat", {31'b0, irq_stat}, 1);
    clr();

    wide = 1'b0; mode = 2'b01; wr_load(32'h0001_2345); restart();
    chk("R10 narrow load", count, 32'h0000_2345);
    do_tick();
    chk("R10 narrow step", count, 32'h0000_2344);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule